// File: doc/BRIEF.md
# Biphase-Mark Audio Frame Transmitter

This block turns a stream of stereo audio sample pairs into a single self-clocking serial line. Every frame carries two sub-frames of 32 slots each, the left channel first and then the right. Each sub-frame opens with a four-slot synchronisation pattern. The slots after it hold the sample, a validity flag, a user bit, one channel-status bit and an even-parity bit. Every slot is sent as two line states using biphase-mark coding. The sync patterns deliberately break that coding so that a receiver can lock onto them.

A frame counter runs from 0 to 191, and one pass through it forms a block. The counter picks the block-start pattern and selects which bit of the 42-bit channel-status word the frame carries. A clock enable `sym_en` paces the output: each enabled cycle emits one line state. With 64 states per sub-frame, the enable must run at 128 times the sample rate. The host presents a sample pair with a one-cycle strobe at any time. The pair is taken at the start of the next frame, and the last pair is sent again if no new one arrived.

The sequencer is a three-state machine. `SEQ_OFF` holds everything idle with the line low. Its only transition, *start*, goes to `SEQ_SYNC` on the first clock edge at which the transmitter is enabled. `SEQ_SYNC` emits the eight preamble states and takes *sync_done* to `SEQ_BODY` after the eighth. `SEQ_BODY` emits the 56 data states and takes *slot_wrap* back to `SEQ_SYNC` after the last one. From either of these two states, the *halt* transition returns to `SEQ_OFF` whenever the enable condition is lost.

Top module: `biphase_frame_tx`

## Requirements
- R1: When `tx_en`, `pwr_on` or `run` is low at a clock edge, `tx_line` is 0 after that edge and the frame, sub-frame and slot positions return to their start. At the first edge where all three are high, no state is emitted. The next enabled state is the first preamble state of sub-frame 1 of frame 0.
- R2: Exactly one line state is emitted per clock edge with `sym_en` high while running. `tx_line` holds its value on other edges. A sub-frame is 64 states (slot n uses states 2n and 2n+1), and sub-frame 1 precedes sub-frame 2.
- R3: Slots 0-3 send an 8-state pattern, leftmost state first. The pattern is 11101000 for the first sub-frame of frame 0, 11100010 for the first sub-frame of every other frame, and 11100100 for every second sub-frame. Each pattern is inverted when the line was 1 just before the pattern began.
- R4: For slots 4-31, the first state of a slot inverts the line. The second state inverts it again for a 1 and holds it for a 0.
- R5: Slots 4-27 carry the 24-bit sample, with slot 4 = bit 0 and slot 27 = bit 23. The left sample goes in sub-frame 1 and the right sample in sub-frame 2. With `short_mode` = 1, slots 4-11 are sent as 0.
- R6: Slot 28 carries `unreliable`, and slot 29 (user data) is always 0.
- R7: Slot 30 of frame n carries `status_bits[n]` for n < 42 and 0 for n ≥ 42, in both sub-frames. The frame number wraps from 191 to 0.
- R8: When `status_bits[0]` = 0, slot 30 of frames 20-23 is overridden. With `stereo` = 1, frame 20 sends 1 in sub-frame 1 only and frame 21 sends 1 in sub-frame 2 only, and all other combinations send 0. With `stereo` = 0, all four frames send 0. When `status_bits[0]` = 1, no override applies.
- R9: Slot 31 makes the number of ones across slots 4-31 even.
- R10: A sample pair given with `smp_stb` is used from the next frame start onward. If no strobe occurs, the previous pair is sent again. A strobe in the same cycle as a frame start takes effect one frame later.
- R11: During `rst_n` = 0, `tx_line` is 0 and the sample pair held is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_en | input | 1 | Line-state enable, 128 per sample period |
| tx_en | input | 1 | Transmitter enable; low forces the line low |
| pwr_on | input | 1 | Power control; low forces the line low |
| run | input | 1 | Timing reset, active low; low restarts the sequence |
| left_smp | input | 24 | Left (channel 1) sample, two's complement |
| right_smp | input | 24 | Right (channel 2) sample, two's complement |
| smp_stb | input | 1 | One-cycle strobe taking `left_smp` and `right_smp` |
| short_mode | input | 1 | 1 = 16-bit samples, low 8 sample slots zero |
| unreliable | input | 1 | Validity flag sent in slot 28 |
| status_bits | input | 42 | Channel-status word, bit n sent in frame n |
| stereo | input | 1 | Selects the stereo override of status bits 20-23 |
| tx_line | output | 1 | Biphase-mark serial output |

## Verification
The bench concentrates on the places where the line polarity carries across slot boundaries. A preamble must follow whatever state the previous parity slot left on the line. A design that ignored that state, or captured it one state late, would send a pattern of the wrong polarity every time the previous sub-frame ended high. It also drives the frame counter through a full block and past the wrap, and checks frames 20-23 under stereo, mono and professional status words. An off-by-one in the frame index or a missing override would show up as a flipped slot-30 state. The sample hand-off is tested with strobes at random moments, including none at all. A design that loaded the pair directly, or mid-frame, would break the parity and sample slots of a sub-frame already in flight. An irregular enable exposes any logic that advances without `sym_en`.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

    localparam int SUB_SLOTS   = 32;
    localparam int SYNC_SLOTS  = 4;
    localparam int SAMPLE_W    = 24;
    localparam int SHORT_W     = 16;
    localparam int VAL_SLOT    = SYNC_SLOTS + SAMPLE_W;
    localparam int USER_SLOT   = VAL_SLOT + 1;
    localparam int CS_SLOT     = VAL_SLOT + 2;
    localparam int PAR_SLOT    = VAL_SLOT + 3;
    localparam int SUB_STATES  = 2 * SUB_SLOTS;
    localparam int SYNC_STATES = 2 * SYNC_SLOTS;
    localparam int IDX_W       = $clog2(SUB_STATES);
    localparam int SLOT_W      = $clog2(SUB_SLOTS);
    localparam int SYNC_W      = $clog2(SYNC_STATES);

    localparam int CHAN_CS_FIRST = 20;
    localparam int CHAN_CS_LAST  = 23;
    localparam int CHAN_CS_LEFT  = 20;
    localparam int CHAN_CS_RIGHT = 21;

    localparam logic [SYNC_STATES-1:0] PAT_BLOCK = 8'b1110_1000;
    localparam logic [SYNC_STATES-1:0] PAT_LEFT  = 8'b1110_0010;
    localparam logic [SYNC_STATES-1:0] PAT_RIGHT = 8'b1110_0100;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_SYNC = 2'd1,
        SEQ_BODY = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bmt_sequencer.sv
module bmt_sequencer
    import bmt_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192,
    localparam int FRAME_W     = $clog2(BLOCK_FRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               sym_en,
    output seq_state_e         state,
    output logic [IDX_W-1:0]   idx,
    output logic               sub,
    output logic [FRAME_W-1:0] frame,
    output logic               emit,
    output logic               in_sync,
    output logic               frame_start
);

    localparam logic [IDX_W-1:0]   LAST_SYNC  = IDX_W'(SYNC_STATES - 1);
    localparam logic [IDX_W-1:0]   LAST_STATE = IDX_W'(SUB_STATES - 1);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(BLOCK_FRAMES - 1);

    seq_state_e nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_OFF;
        end else begin
            state <= nxt;
        end
    end

    // transitions: start, sync_done, slot_wrap, halt
    always_comb begin
        nxt = state;
        unique case (state)
            SEQ_OFF: begin
                if (active) nxt = SEQ_SYNC;
            end
            SEQ_SYNC: begin
                if (!active)                          nxt = SEQ_OFF;
                else if (sym_en && idx == LAST_SYNC)  nxt = SEQ_BODY;
            end
            SEQ_BODY: begin
                if (!active)                          nxt = SEQ_OFF;
                else if (sym_en && idx == LAST_STATE) nxt = SEQ_SYNC;
            end
            default: nxt = SEQ_OFF;
        endcase
    end

    // outputs
    always_comb begin
        emit        = active && sym_en && (state != SEQ_OFF);
        in_sync     = (state == SEQ_SYNC);
        frame_start = emit && (idx == '0) && !sub;
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            sub   <= 1'b0;
            frame <= '0;
        end else if (!active) begin
            idx   <= '0;
            sub   <= 1'b0;
            frame <= '0;
        end else if (emit) begin
            if (idx == LAST_STATE) begin
                idx <= '0;
                if (sub) begin
                    sub   <= 1'b0;
                    frame <= (frame == LAST_FRAME) ? '0 : frame + 1'b1;
                end else begin
                    sub <= 1'b1;
                end
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bmt_slot_builder.sv
module bmt_slot_builder
    import bmt_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192,
    parameter int STATUS_BITS  = 42,
    localparam int FRAME_W     = $clog2(BLOCK_FRAMES)
) (
    input  logic [SLOT_W-1:0]      slot,
    input  logic                   sub,
    input  logic [FRAME_W-1:0]     frame,
    input  logic [SAMPLE_W-1:0]    smp_l,
    input  logic [SAMPLE_W-1:0]    smp_r,
    input  logic                   short_mode,
    input  logic                   unreliable,
    input  logic [STATUS_BITS-1:0] status_bits,
    input  logic                   stereo,
    output logic                   slot_bit,
    output logic [SYNC_STATES-1:0] pre_pat
);

    logic [SAMPLE_W-1:0]    smp;
    logic [STATUS_BITS-1:0] cs_shift;
    logic                   cs_plain;
    logic                   cs_bit;
    logic                   chan_zone;
    logic [SUB_SLOTS-1:0]   word;
    int                     fnum;

    always_comb begin
        fnum      = 32'(frame);
        cs_shift  = status_bits >> frame;
        cs_plain  = (fnum < STATUS_BITS) ? cs_shift[0] : 1'b0;
        chan_zone = !status_bits[0] && (fnum >= CHAN_CS_FIRST) && (fnum <= CHAN_CS_LAST);
        if (chan_zone) begin
            cs_bit = stereo && ((!sub && fnum == CHAN_CS_LEFT) || (sub && fnum == CHAN_CS_RIGHT));
        end else begin
            cs_bit = cs_plain;
        end
    end

    always_comb begin
        smp  = sub ? smp_r : smp_l;
        word = '0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            word[SYNC_SLOTS + i] = (short_mode && i < SAMPLE_W - SHORT_W) ? 1'b0 : smp[i];
        end
        word[VAL_SLOT]  = unreliable;
        word[USER_SLOT] = 1'b0;
        word[CS_SLOT]   = cs_bit;
        word[PAR_SLOT]  = ^word[PAR_SLOT-1:SYNC_SLOTS];
        slot_bit        = word[slot];
    end

    always_comb begin
        if (sub)                pre_pat = PAT_RIGHT;
        else if (frame == '0)   pre_pat = PAT_BLOCK;
        else                    pre_pat = PAT_LEFT;
    end

endmodule

// File: rtl/bmt_encoder.sv
module bmt_encoder
    import bmt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  logic                   emit,
    input  logic                   in_sync,
    input  logic [SYNC_W-1:0]      sync_k,
    input  logic                   half,
    input  logic [SYNC_STATES-1:0] pre_pat,
    input  logic                   slot_bit,
    output logic                   line
);

    localparam logic [SYNC_W-1:0] TOP_K = SYNC_W'(SYNC_STATES - 1);

    logic pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line <= 1'b0;
            pol  <= 1'b0;
        end else if (!active) begin
            line <= 1'b0;
        end else if (emit) begin
            if (in_sync) begin
                if (sync_k == '0) begin
                    pol  <= line;
                    line <= pre_pat[TOP_K] ^ line;
                end else begin
                    line <= pre_pat[TOP_K - sync_k] ^ pol;
                end
            end else if (!half) begin
                line <= ~line;
            end else if (slot_bit) begin
                line <= ~line;
            end
        end
    end

endmodule

// File: rtl/biphase_frame_tx.sv
module biphase_frame_tx
    import bmt_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192,
    parameter int STATUS_BITS  = 42,
    localparam int FRAME_W     = $clog2(BLOCK_FRAMES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sym_en,
    input  logic                   tx_en,
    input  logic                   pwr_on,
    input  logic                   run,
    input  logic [SAMPLE_W-1:0]    left_smp,
    input  logic [SAMPLE_W-1:0]    right_smp,
    input  logic                   smp_stb,
    input  logic                   short_mode,
    input  logic                   unreliable,
    input  logic [STATUS_BITS-1:0] status_bits,
    input  logic                   stereo,
    output logic                   tx_line
);

    logic                   active;
    seq_state_e             seq_state;
    logic [IDX_W-1:0]       seq_idx;
    logic                   seq_sub;
    logic [FRAME_W-1:0]     seq_frame;
    logic                   emit;
    logic                   in_sync;
    logic                   frame_start;
    logic [SAMPLE_W-1:0]    pend_l, pend_r;
    logic [SAMPLE_W-1:0]    cur_l, cur_r;
    logic                   slot_bit;
    logic [SYNC_STATES-1:0] pre_pat;

    assign active = tx_en && pwr_on && run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_l <= '0;
            pend_r <= '0;
        end else if (smp_stb) begin
            pend_l <= left_smp;
            pend_r <= right_smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_l <= '0;
            cur_r <= '0;
        end else if (frame_start) begin
            cur_l <= pend_l;
            cur_r <= pend_r;
        end
    end

    bmt_sequencer #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .sym_en      (sym_en),
        .state       (seq_state),
        .idx         (seq_idx),
        .sub         (seq_sub),
        .frame       (seq_frame),
        .emit        (emit),
        .in_sync     (in_sync),
        .frame_start (frame_start)
    );

    bmt_slot_builder #(.BLOCK_FRAMES(BLOCK_FRAMES), .STATUS_BITS(STATUS_BITS)) u_slot (
        .slot        (seq_idx[IDX_W-1:1]),
        .sub         (seq_sub),
        .frame       (seq_frame),
        .smp_l       (cur_l),
        .smp_r       (cur_r),
        .short_mode  (short_mode),
        .unreliable  (unreliable),
        .status_bits (status_bits),
        .stereo      (stereo),
        .slot_bit    (slot_bit),
        .pre_pat     (pre_pat)
    );

    bmt_encoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .emit     (emit),
        .in_sync  (in_sync),
        .sync_k   (seq_idx[SYNC_W-1:0]),
        .half     (seq_idx[0]),
        .pre_pat  (pre_pat),
        .slot_bit (slot_bit),
        .line     (tx_line)
    );

endmodule

// File: rtl/bmt_checker.sv
module bmt_checker
    import bmt_pkg::*;
#(
    parameter int BLOCK_FRAMES = 192,
    localparam int FRAME_W     = $clog2(BLOCK_FRAMES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_en,
    input logic               pwr_on,
    input logic               run,
    input logic               sym_en,
    input logic               tx_line,
    input seq_state_e         st,
    input logic [IDX_W-1:0]   idx,
    input logic [FRAME_W-1:0] frame
);

    logic on;
    assign on = tx_en && pwr_on && run;

    // R1
    line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> !tx_line);

    // R1
    seq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (st == SEQ_OFF) && (idx == '0) && (frame == '0));

    // R2
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !sym_en) |=> $stable(tx_line));

    // R4
    slot_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (on && sym_en && st == SEQ_BODY && !idx[0]) |=> (tx_line != $past(tx_line)));

    // R3
    sync_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_SYNC) |-> (32'(idx) < SYNC_STATES));

    // R7
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(frame) < BLOCK_FRAMES);

endmodule

bind biphase_frame_tx bmt_checker #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .pwr_on  (pwr_on),
    .run     (run),
    .sym_en  (sym_en),
    .tx_line (tx_line),
    .st      (seq_state),
    .idx     (seq_idx),
    .frame   (seq_frame)
);

// File: tb/biphase_frame_tx_test.sv
`timescale 1ns/1ps
module biphase_frame_tx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_en = 1'b0;
    logic        tx_en = 1'b0;
    logic        pwr_on = 1'b0;
    logic        run = 1'b0;
    logic [23:0] left_smp = '0;
    logic [23:0] right_smp = '0;
    logic        smp_stb = 1'b0;
    logic        short_mode = 1'b0;
    logic        unreliable = 1'b0;
    logic [41:0] status_bits = '0;
    logic        stereo = 1'b0;
    logic        tx_line;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit stb_on = 1'b0;
    bit done = 1'b0;

    biphase_frame_tx uut (
        .clk(clk), .rst_n(rst_n), .sym_en(sym_en), .tx_en(tx_en), .pwr_on(pwr_on),
        .run(run), .left_smp(left_smp), .right_smp(right_smp), .smp_stb(smp_stb),
        .short_mode(short_mode), .unreliable(unreliable), .status_bits(status_bits),
        .stereo(stereo), .tx_line(tx_line)
    );

    always #2.5 clk = ~clk;

    // ---------------- behavioural reference ----------------
    bit          m_run, m_line, m_pol, m_fresh, m_pend_new;
    int          m_idx, m_sub, m_frame;
    logic [23:0] m_cur_l, m_cur_r, m_pend_l, m_pend_r;
    string       m_tag = "R11";

    function automatic bit cs_of(int fr, int sb);
        if (!status_bits[0] && fr >= 20 && fr <= 23)
            return stereo && ((sb == 0 && fr == 20) || (sb == 1 && fr == 21));
        if (fr >= 42) return 1'b0;
        return status_bits[fr];
    endfunction

    function automatic bit word_bit(int s);
        logic [23:0] smp;
        bit p;
        smp = (m_sub == 0) ? m_cur_l : m_cur_r;
        if (s >= 4 && s <= 27) return (short_mode && (s - 4) < 8) ? 1'b0 : smp[s-4];
        if (s == 28) return unreliable;
        if (s == 29) return 1'b0;
        if (s == 30) return cs_of(m_frame, m_sub);
        p = 1'b0;
        for (int k = 4; k <= 30; k++) p = p ^ word_bit(k);
        return p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_line = 0; m_pol = 0; m_fresh = 0; m_pend_new = 0;
            m_idx = 0; m_sub = 0; m_frame = 0;
            m_cur_l = '0; m_cur_r = '0; m_pend_l = '0; m_pend_r = '0;
            m_tag = "R11";
        end else begin
            if (!(tx_en && pwr_on && run)) begin
                m_run = 0; m_idx = 0; m_sub = 0; m_frame = 0; m_line = 0;
                m_tag = "R1";
            end else if (!m_run) begin
                m_run = 1;
                m_tag = "R1";
            end else if (sym_en) begin
                int s;
                if (m_idx == 0 && m_sub == 0) begin
                    m_cur_l = m_pend_l; m_cur_r = m_pend_r;
                    m_fresh = m_pend_new; m_pend_new = 0;
                end
                s = m_idx / 2;
                if (s < 4) begin
                    logic [7:0] pat;
                    if (m_sub == 1)        pat = 8'b11100100;
                    else if (m_frame == 0) pat = 8'b11101000;
                    else                   pat = 8'b11100010;
                    if (m_idx == 0) m_pol = m_line;
                    m_line = pat[7 - m_idx] ^ m_pol;
                    m_tag = "R3";
                end else if (m_idx % 2 == 0) begin
                    m_line = !m_line;
                    m_tag = "R4";
                end else begin
                    if (word_bit(s)) m_line = !m_line;
                    if (s <= 27)      m_tag = m_fresh ? "R5" : "R10";
                    else if (s <= 29) m_tag = "R6";
                    else if (s == 30) m_tag = (!status_bits[0] && m_frame >= 20 && m_frame <= 23) ? "R8" : "R7";
                    else              m_tag = "R9";
                end
                m_idx++;
                if (m_idx == 64) begin
                    m_idx = 0;
                    if (m_sub == 1) begin
                        m_sub = 0;
                        m_frame = (m_frame + 1) % 192;
                    end else m_sub = 1;
                end
            end else begin
                m_tag = "R2";
            end
            if (smp_stb) begin
                m_pend_l = left_smp; m_pend_r = right_smp; m_pend_new = 1;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (tx_line !== m_line) begin
                errors++;
                $display("FAIL %s: tx_line=%0b expected=%0b frame=%0d sub=%0d idx=%0d",
                         m_tag, tx_line, m_line, m_frame, m_sub, m_idx);
            end
        end
    end

    // enable and sample source
    always @(negedge clk) begin
        sym_en <= ($urandom % 4) != 0;
        if (stb_on && ($urandom % 150) == 0) begin
            smp_stb   <= 1'b1;
            left_smp  <= $urandom;
            right_smp <= $urandom;
        end else begin
            smp_stb <= 1'b0;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL R2 watchdog: cycles=%0d expected below 190000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R11: reset state
        wait_cycles(6);
        rst_n = 1'b1;
        wait_cycles(4);

        // R3 R5 R7 R8: stereo consumer word, 24-bit, changing samples, past the block wrap
        status_bits = 42'h2A5_0F0F_3C04;
        status_bits[0] = 1'b0;
        stereo = 1'b1;
        stb_on = 1'b1;
        tx_en = 1'b1; pwr_on = 1'b1; run = 1'b1;
        wait_cycles(36000);

        // R1: transmitter disable mid-frame, then R10 repeat with 16-bit mode
        tx_en = 1'b0;
        wait_cycles(20);
        stb_on = 1'b0;
        wait_cycles(5);
        short_mode = 1'b1; unreliable = 1'b1; stereo = 1'b0;
        tx_en = 1'b1;
        wait_cycles(5200);

        // R1: power-down, then professional word (no override) with stereo set
        pwr_on = 1'b0;
        wait_cycles(10);
        status_bits = 42'h3FF_FFF0_F00F;
        status_bits[0] = 1'b1;
        stereo = 1'b1; short_mode = 1'b0; unreliable = 1'b0;
        stb_on = 1'b1;
        pwr_on = 1'b1;
        wait_cycles(5200);

        // R1: timing reset, then stereo consumer word again with mono flag off
        run = 1'b0;
        wait_cycles(8);
        status_bits[0] = 1'b0;
        run = 1'b1;
        wait_cycles(5200);
        tx_en = 1'b0;
        wait_cycles(10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule